// File: doc/BRIEF.md
# LDPC Check Node Processor

This block performs the check node update of a log-domain belief propagation decoder for a (3,6)-regular low-density parity-check code. Each cycle it accepts six hybrid words, one from each variable node attached to the check. Each word carries a hard-decision bit and a 5-bit sign-magnitude variable-to-check message. It returns six 5-bit check-to-variable messages and a bit that flags a failed parity check.

The sign path and the magnitude path are handled separately. Every input magnitude goes through a combinational forward table that approximates f(x) = ln((1+e^-x)/(1-e^-x)). The six table values are summed. For each output, that output's own term is taken out of the sum, and the result is mapped back through the same table to a 4-bit magnitude. Each output sign is the XOR of the other five input signs. One pipeline register splits the logic into a table/sum half and a subtract/inverse half. The output register follows, so a new set of six words can enter every cycle and each set returns two cycles later. A decoder controller collects the parity bit from every check node to decide when to stop iterating.

Top module: `ldpc_cnode_proc`

## Requirements
- R1: Input word i occupies in_word[6i+5:6i]: bit 5 is the hard decision, bit 4 the message sign (1 = negative) and bits 3:0 the magnitude. Output message i occupies out_msg[5i+4:5i], with bit 4 the sign and bits 3:0 the magnitude.
- R2: The forward table maps magnitude m to a 6-bit value: m=0 to 63, 1 to 23, 2 to 12, 3 to 7, 4 to 4, 5 to 3, 6 to 2, 7 and 8 to 1, and 9 through 15 to 0.
- R3: The six forward values are summed without loss at 9 bits. Output i uses that sum minus input i's own forward value.
- R4: The inverse map turns the reduced sum s into the count of magnitudes m in 1..15 whose forward value is at least s. This saturates at 15 for s=0 and gives 0 once s exceeds 23.
- R5: The sign of output i is the XOR of the signs of the five other inputs. This holds even when the output magnitude is zero.
- R6: parity_odd equals the XOR of the six hard-decision bits sampled two cycles earlier. It is updated on every cycle whether or not in_valid is high.
- R7: A set sampled with in_valid high appears on out_msg with out_valid high exactly two cycles later. Back-to-back sets stream at one per cycle.
- R8: When in_valid is low, out_valid falls two cycles later and out_msg keeps the last computed messages.
- R9: While rst_n is low, out_valid, out_msg and parity_odd are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | The six input words are valid this cycle |
| in_word | input | 36 | Six packed hybrid words (hard decision, sign, magnitude) |
| out_valid | output | 1 | out_msg holds a new result |
| out_msg | output | 30 | Six packed sign-magnitude check-to-variable messages |
| parity_odd | output | 1 | 1 when the hard decisions from two cycles earlier have odd parity |

## Verification
The assertions check the cycle-level properties on every cycle. They cover the two-cycle valid latency, the holding of out_msg while no set arrives, the parity bit against the hard decisions from two cycles earlier, and the XOR of all output signs against the XOR of the input signs. They also check that six zero-magnitude inputs give all-zero output magnitudes. The per-output magnitude values cannot be checked by a simple property: the table contents, the own-term subtraction and the saturation at 15 and at 0. The bench scenarios show these. They combine directed corner sets (all-zero, all-maximum, a single weak input, mixed signs) with random sets biased toward large magnitudes so that the outputs cover the whole range.

// File: rtl/ldpc_cn_pkg.sv
package ldpc_cn_pkg;
  localparam int CN_MAG_W = 4;
  localparam int CN_LUT_W = 6;

  // Quantised f(x): input step 0.5, output step 1/16, zero magnitude pinned high
  function automatic logic [CN_LUT_W-1:0] cn_fwd_val(input logic [CN_MAG_W-1:0] m);
    case (m)
      4'd0:    cn_fwd_val = 6'd63;
      4'd1:    cn_fwd_val = 6'd23;
      4'd2:    cn_fwd_val = 6'd12;
      4'd3:    cn_fwd_val = 6'd7;
      4'd4:    cn_fwd_val = 6'd4;
      4'd5:    cn_fwd_val = 6'd3;
      4'd6:    cn_fwd_val = 6'd2;
      4'd7:    cn_fwd_val = 6'd1;
      4'd8:    cn_fwd_val = 6'd1;
      default: cn_fwd_val = 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/ldpc_cn_fwd_lut.sv
module ldpc_cn_fwd_lut
  import ldpc_cn_pkg::*;
(
  input  logic [CN_MAG_W-1:0] mag_i,
  output logic [CN_LUT_W-1:0] val_o
);
  always_comb val_o = cn_fwd_val(mag_i);
endmodule

// File: rtl/ldpc_cn_inv_lut.sv
module ldpc_cn_inv_lut
  import ldpc_cn_pkg::*;
#(
  parameter int SUM_W = 9
) (
  input  logic [SUM_W-1:0]    sum_i,
  output logic [CN_MAG_W-1:0] mag_o
);
  localparam int NMAG = (1 << CN_MAG_W) - 1;

  logic [CN_MAG_W:0] cnt;

  // Count of table entries (excluding m=0) at or above the reduced sum
  always_comb begin
    cnt = '0;
    for (int m = 1; m <= NMAG; m++) begin
      if ({{(SUM_W-CN_LUT_W){1'b0}}, cn_fwd_val(CN_MAG_W'(m))} >= sum_i)
        cnt = cnt + 1'b1;
    end
    mag_o = cnt[CN_MAG_W-1:0];
  end
endmodule

// File: rtl/ldpc_cnode_proc.sv
module ldpc_cnode_proc
  import ldpc_cn_pkg::*;
#(
  parameter int DEG   = 6,
  parameter int SUM_W = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [DEG*(CN_MAG_W+2)-1:0]     in_word,
  output logic                            out_valid,
  output logic [DEG*(CN_MAG_W+1)-1:0]     out_msg,
  output logic                            parity_odd
);
  localparam int MSG_W  = CN_MAG_W + 1;
  localparam int WORD_W = CN_MAG_W + 2;

  // ---------------- stage 1: field split, forward table, sum ----------------
  logic [DEG-1:0][CN_MAG_W-1:0] in_mag;
  logic [DEG-1:0]               in_sgn;
  logic [DEG-1:0]               in_hd;
  logic [DEG-1:0][CN_LUT_W-1:0] fwd_val;

  genvar gi;
  generate
    for (gi = 0; gi < DEG; gi++) begin : g_fwd
      assign in_mag[gi] = in_word[gi*WORD_W +: CN_MAG_W];
      assign in_sgn[gi] = in_word[gi*WORD_W + CN_MAG_W];
      assign in_hd[gi]  = in_word[gi*WORD_W + CN_MAG_W + 1];
      ldpc_cn_fwd_lut u_fwd (.mag_i(in_mag[gi]), .val_o(fwd_val[gi]));
    end
  endgenerate

  logic [SUM_W-1:0] sum_d;
  always_comb begin
    sum_d = '0;
    for (int i = 0; i < DEG; i++)
      sum_d = sum_d + {{(SUM_W-CN_LUT_W){1'b0}}, fwd_val[i]};
  end

  logic                         s1_vld_q;
  logic [SUM_W-1:0]             s1_sum_q;
  logic [DEG-1:0][CN_LUT_W-1:0] s1_own_q;
  logic [DEG-1:0]               s1_sgn_q;
  logic                         s1_par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_par_q <= 1'b0;
      s1_sum_q <= '0;
      s1_own_q <= '0;
      s1_sgn_q <= '0;
    end else begin
      s1_vld_q <= in_valid;
      s1_par_q <= ^in_hd;
      if (in_valid) begin
        s1_sum_q <= sum_d;
        s1_own_q <= fwd_val;
        s1_sgn_q <= in_sgn;
      end
    end
  end

  // ---------------- stage 2: own-term removal, inverse table, signs ---------
  logic                    tot_sgn;
  logic [DEG*MSG_W-1:0]    msg_d;

  assign tot_sgn = ^s1_sgn_q;

  generate
    for (gi = 0; gi < DEG; gi++) begin : g_inv
      logic [SUM_W-1:0]    red_sum;
      logic [CN_MAG_W-1:0] out_mag;
      assign red_sum = s1_sum_q - {{(SUM_W-CN_LUT_W){1'b0}}, s1_own_q[gi]};
      ldpc_cn_inv_lut #(.SUM_W(SUM_W)) u_inv (.sum_i(red_sum), .mag_o(out_mag));
      assign msg_d[gi*MSG_W +: MSG_W] = {tot_sgn ^ s1_sgn_q[gi], out_mag};
    end
  endgenerate

  logic                 out_vld_q;
  logic [DEG*MSG_W-1:0] out_msg_q;
  logic                 out_par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q <= 1'b0;
      out_par_q <= 1'b0;
      out_msg_q <= '0;
    end else begin
      out_vld_q <= s1_vld_q;
      out_par_q <= s1_par_q;
      if (s1_vld_q) out_msg_q <= msg_d;
    end
  end

  assign out_valid  = out_vld_q;
  assign out_msg    = out_msg_q;
  assign parity_odd = out_par_q;
endmodule

// File: rtl/ldpc_cnode_chk.sv
module ldpc_cnode_chk
  import ldpc_cn_pkg::*;
#(
  parameter int DEG = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic [DEG*(CN_MAG_W+2)-1:0] in_word,
  input logic                        out_valid,
  input logic [DEG*(CN_MAG_W+1)-1:0] out_msg,
  input logic                        parity_odd
);
  localparam int MSG_W  = CN_MAG_W + 1;
  localparam int WORD_W = CN_MAG_W + 2;

  logic in_sx, in_hx, out_sx, in_magz, out_magz;
  always_comb begin
    in_sx = 1'b0; in_hx = 1'b0; out_sx = 1'b0; in_magz = 1'b1; out_magz = 1'b1;
    for (int i = 0; i < DEG; i++) begin
      in_sx  = in_sx  ^ in_word[i*WORD_W + CN_MAG_W];
      in_hx  = in_hx  ^ in_word[i*WORD_W + CN_MAG_W + 1];
      out_sx = out_sx ^ out_msg[i*MSG_W + CN_MAG_W];
      if (in_word[i*WORD_W +: CN_MAG_W] != '0) in_magz = 1'b0;
      if (out_msg[i*MSG_W +: CN_MAG_W] != '0)  out_magz = 1'b0;
    end
  end

  // R7
  vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  // R8
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
  // R8
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 $stable(out_msg));
  // R6
  parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ##1 (parity_odd == $past(in_hx, 2)));
  // R5
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 (out_sx == $past(in_sx, 2)));
  // R4
  zero_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_magz) |=> ##1 out_magz);
endmodule

bind ldpc_cnode_proc ldpc_cnode_chk #(.DEG(DEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .out_msg(out_msg), .parity_odd(parity_odd)
);

// File: tb/ldpc_cnode_proc_tb.sv
module ldpc_cnode_proc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [35:0] in_word = '0;
  logic        out_valid;
  logic [29:0] out_msg;
  logic        parity_odd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ldpc_cnode_proc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_msg(out_msg), .parity_odd(parity_odd)
  );

  // R2 table
  function automatic int tab(input int m);
    case (m)
      0: return 63; 1: return 23; 2: return 12; 3: return 7; 4: return 4;
      5: return 3;  6: return 2;  7: return 1;  8: return 1;
      default: return 0;
    endcase
  endfunction

  // R4 inverse rule
  function automatic int inv_ref(input int s);
    int n = 0;
    for (int m = 1; m <= 15; m++) if (tab(m) >= s) n++;
    return n;
  endfunction

  // R1, R3, R5 expected messages
  function automatic logic [29:0] exp_msgs(input logic [35:0] w);
    logic [29:0] r;
    int sum = 0;
    logic tot = 1'b0;
    for (int i = 0; i < 6; i++) begin
      sum += tab(int'(w[6*i +: 4]));
      tot ^= w[6*i+4];
    end
    for (int i = 0; i < 6; i++) begin
      r[5*i+4]   = tot ^ w[6*i+4];
      r[5*i +: 4] = 4'(inv_ref(sum - tab(int'(w[6*i +: 4]))));
    end
    return r;
  endfunction

  function automatic logic exp_par(input logic [35:0] w);
    logic p = 1'b0;
    for (int i = 0; i < 6; i++) p ^= w[6*i+5];
    return p;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] rand_word(input int mode);
    logic [35:0] w;
    w = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
    if (mode == 1)       // strong inputs: small table values, wide output range
      for (int i = 0; i < 6; i++) w[6*i +: 4] = 4'(6 + ($urandom % 10));
    else if (mode == 2)  // one weak input among strong ones
      for (int i = 0; i < 6; i++)
        w[6*i +: 4] = (i == ($urandom % 6)) ? 4'($urandom % 3) : 4'(7 + ($urandom % 9));
    return w;
  endfunction

  // One set in flight per call: drive, then two edges, then check
  task automatic one_set(input string req, input logic [35:0] w);
    @(negedge clk); in_word = w; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check({req, " msg"}, 64'(out_msg), 64'(exp_msgs(w)));
    check("R7 valid", 64'(out_valid), 64'd1);
    check({req, " R6 parity"}, 64'(parity_odd), 64'(exp_par(w)));
  endtask

  function automatic logic [35:0] mk(input logic [5:0] a, b, c, d, e, f);
    return {f, e, d, c, b, a};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [35:0] vec [0:299];
    logic [29:0] held;
    void'($urandom(32'd1234));

    // R9 reset state
    in_word = '1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 out_valid", 64'(out_valid), 64'd0);
    check("R9 out_msg", 64'(out_msg), 64'd0);
    check("R9 parity", 64'(parity_odd), 64'd0);
    rst_n = 1'b1;
    in_word = '0;

    // Directed corners
    one_set("R4 all zero mag", mk(6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00));
    check("R4 all zero mag -> 0", 64'(out_msg), 64'd0);
    // all magnitude 15: reduced sum 0 -> 15, signs all positive
    one_set("R4 saturate 15", mk(6'h0F, 6'h0F, 6'h0F, 6'h0F, 6'h0F, 6'h0F));
    check("R4 saturate 15 value", 64'(out_msg), 64'(30'h1EF7BDEF));
    // one weak input (m=2) among m=15: weak gets 15, others get 2 (s=12)
    one_set("R3 own term", mk(6'h02, 6'h0F, 6'h0F, 6'h0F, 6'h0F, 6'h0F));
    check("R3 own term out0", 64'(out_msg[4:0]), 64'd15);
    check("R3 own term out1", 64'(out_msg[9:5]), 64'd2);
    // R5 mixed signs, one negative input: others negative, itself positive
    one_set("R5 sign", mk(6'h1F, 6'h0F, 6'h0F, 6'h0F, 6'h0F, 6'h0F));
    check("R5 own sign", 64'(out_msg[4]), 64'd0);
    check("R5 other sign", 64'(out_msg[9]), 64'd1);
    // R2 table points m=4 with strong rest: s=4 -> 4
    one_set("R2 table", mk(6'h04, 6'h0F, 6'h0F, 6'h0F, 6'h0F, 6'h0F));
    check("R2 table m4", 64'(out_msg[9:5]), 64'd4);
    one_set("R6 odd hd", mk(6'h20, 6'h00, 6'h00, 6'h00, 6'h00, 6'h0F));

    // R8 hold while idle, parity still tracks
    held = out_msg;
    @(negedge clk); in_word = mk(6'h25, 6'h13, 6'h20, 6'h07, 6'h01, 6'h0C); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 hold msg", 64'(out_msg), 64'(held));
    check("R8 valid low", 64'(out_valid), 64'd0);
    check("R6 idle parity", 64'(parity_odd), 64'(exp_par(in_word)));

    // R7 streaming, one set per cycle, random biased stimulus
    for (int k = 0; k < 300; k++) vec[k] = rand_word(k % 3);
    for (int j = 0; j < 302; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        check("R7 stream valid", 64'(out_valid), 64'd1);
        check("R1 R3 R4 R5 stream msg", 64'(out_msg), 64'(exp_msgs(vec[j-2])));
        check("R6 stream parity", 64'(parity_odd), 64'(exp_par(vec[j-2])));
      end
      if (j < 300) begin in_word = vec[j]; in_valid = 1'b1; end
      else in_valid = 1'b0;
    end
    @(negedge clk);
    check("R8 drop valid", 64'(out_valid), 64'd0);
    check("R8 last held", 64'(out_msg), 64'(exp_msgs(vec[299])));

    // R9 asynchronous reset mid-run
    @(negedge clk); in_word = vec[5]; in_valid = 1'b1;
    @(negedge clk); rst_n = 1'b0; #1;
    check("R9 async clear valid", 64'(out_valid), 64'd0);
    check("R9 async clear msg", 64'(out_msg), 64'd0);
    in_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule